// File: doc/BRIEF.md
# PHY Management Access Register Controller

This block is the host-visible side of a PHY management path. A host CPU reaches external PHY registers indirectly: it writes one 32-bit access word holding a 16-bit data value, a 5-bit PHY address, a 5-bit register number and two command bits. Setting a command bit hands a frame request to a separate management frame engine through a start/done handshake. When the engine finishes a read, the returned value is captured into the data field. A completion flag and a latched read-error status, with a maskable interrupt, report the outcome.

The host port is a plain single-beat read/write port. Every request is taken in the cycle it is presented, so there is no ready signal. A read is answered one cycle later with `rsp_valid`. Back-pressure takes one form only: in blocking mode, a read of the access word made while a frame is running returns `rsp_retry` in place of data, and the host must reissue it later. In non-blocking mode reads are never refused, and the host polls the completion flag instead. The engine side is a one-cycle `eng_start` pulse with operands held stable until the engine returns a one-cycle `eng_done`.

Top module: `phy_acc_regctl`

## Requirements
- R1: After reset, both host words (address 0 access word, address 1 control word) read as zero, `eng_start` is low, `err_irq` is low and blocking mode is off.
- R2: A host write to address 0 with bit 26 set, while no frame is running, loads data [15:0], register number [20:16] and PHY address [25:21]. In the next cycle it raises `eng_start` for exactly one cycle, with `eng_write`=1 and those fields on the engine operand ports.
- R3: Bit 27 set (bit 26 clear) launches a read frame (`eng_write`=0). On `eng_done`, `eng_rdata` is captured into access bits [15:0].
- R4: With control bit 1 (blocking) set, a read of address 0 while a frame runs is answered with `rsp_retry`=1 and `rsp_rdata`=0. Any other read gets `rsp_retry`=0 and the register contents.
- R5: Access bit 28 (done) is cleared by an accepted command and set by `eng_done`. While a frame runs, bit 26 reads 1 for a write frame and bit 27 reads 1 for a read frame. Both read 0 when idle.
- R6: `eng_rderr` with `eng_done` on a read frame sets control bit 8 (error status). On a write frame it is ignored.
- R7: `err_irq` is high exactly when control bit 8 and control bit 0 (error enable) are both 1.
- R8: A host write to address 0 while a frame runs, including in the cycle `eng_done` arrives, is dropped: no field changes and no frame starts.
- R9: A command naming PHY address 1Fh is rejected as a whole: no frame starts and no field changes.
- R10: Writing 1 to control bit 8 clears the error status, and `err_irq` falls after that clock edge. A read error arriving in the same cycle wins, and the status stays set.
- R11: A write to address 0 with both command bits clear updates the fields, starts no frame and leaves the done bit unchanged.
- R12: A write with bits 26 and 27 both set launches a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 access, 1 control) |
| bus_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response present |
| rsp_retry | output | 1 | Read refused, reissue later |
| rsp_rdata | output | 32 | Read data |
| eng_start | output | 1 | One-cycle frame launch pulse |
| eng_write | output | 1 | Frame type, 1 = write |
| eng_phy | output | 5 | PHY address operand |
| eng_reg | output | 5 | Register number operand |
| eng_wdata | output | 16 | Write data operand |
| eng_done | input | 1 | Frame finished pulse |
| eng_rdata | input | 16 | Data returned by a read frame |
| eng_rderr | input | 1 | Read frame failed, valid with eng_done |
| err_irq | output | 1 | Maskable read-error interrupt |

## Verification
Two pairs of events can land on the same clock edge. One is a frame completion together with a new host command. The other is a write-1 clear of the error status together with a failing read completion. The bench provokes each by driving `eng_done` and the host write in one cycle. In the first case it judges that the command is dropped, the returned data is kept and no `eng_start` follows. In the second it judges that the error bit and `err_irq` remain high. Random traffic then mixes commands, busy-time writes, reserved addresses, mode changes and completions against a bench model.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int WORD_W  = 32;
  localparam int BUS_AW  = 2;
  // access word bit positions (host-visible layout)
  localparam int F_DATA  = 0;
  localparam int F_REG   = F_DATA + DATA_W;
  localparam int F_PHY   = F_REG + ADDR_W;
  localparam int F_WR    = F_PHY + ADDR_W;
  localparam int F_RD    = F_WR + 1;
  localparam int F_DONE  = F_RD + 1;
  // control word bit positions
  localparam int C_EN    = 0;
  localparam int C_BLK   = 1;
  localparam int C_ERR   = 8;
  localparam logic [ADDR_W-1:0] RSVD_PHY = '1;
  localparam logic [BUS_AW-1:0] A_ACC  = 0;
  localparam logic [BUS_AW-1:0] A_CTRL = 1;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } acc_fields_t;
endpackage

// File: rtl/phy_acc_cmd.sv
module phy_acc_cmd
  import phy_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_rderr,
  output logic              eng_start,
  output logic              is_wr,
  output acc_fields_t       fields,
  output logic              busy,
  output logic              done,
  output logic              rd_err_evt
);
  logic cmd_req, rsvd, upd, launch, finish;

  assign cmd_req = wdata[F_WR] | wdata[F_RD];
  assign rsvd    = (wdata[F_PHY +: ADDR_W] == RSVD_PHY);
  assign upd     = wr_acc && !busy && !(cmd_req && rsvd);
  assign launch  = upd && cmd_req;
  assign finish  = eng_done && busy;
  assign rd_err_evt = finish && !is_wr && eng_rderr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      is_wr     <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= launch;
      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!is_wr) fields.data <= eng_rdata;
      end
      if (upd) begin
        fields.data <= wdata[F_DATA +: DATA_W];
        fields.regn <= wdata[F_REG +: ADDR_W];
        fields.phy  <= wdata[F_PHY +: ADDR_W];
      end
      if (launch) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        is_wr <= wdata[F_WR];
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R2
  AST_NO_RSVD_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> fields.phy != RSVD_PHY); // R9
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (busy && !done)); // R5
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fields)); // R8
endmodule

// File: rtl/phy_acc_stat.sv
module phy_acc_stat
  import phy_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              err_evt,
  output logic              err,
  output logic              err_en,
  output logic              blk_mode,
  output logic              irq
);
  logic clr;
  assign clr = wr_ctrl && wdata[C_ERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err      <= 1'b0;
      err_en   <= 1'b0;
      blk_mode <= 1'b0;
    end else begin
      if (err_evt)  err <= 1'b1;
      else if (clr) err <= 1'b0;
      if (wr_ctrl) begin
        err_en   <= wdata[C_EN];
        blk_mode <= wdata[C_BLK];
      end
    end
  end

  assign irq = err & err_en;

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err); // R6
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_evt) |=> !irq); // R10
endmodule

// File: rtl/phy_acc_regctl.sv
module phy_acc_regctl
  import phy_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              eng_start,
  output logic              eng_write,
  output logic [ADDR_W-1:0] eng_phy,
  output logic [ADDR_W-1:0] eng_reg,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_rderr,
  output logic              err_irq
);
  logic        wr_acc, wr_ctrl, rd_req, busy, done, is_wr, rd_err_evt;
  logic        err, err_en, blk_mode, refuse;
  acc_fields_t fields;
  logic [WORD_W-1:0] acc_word, ctrl_word, rd_mux;

  assign wr_acc  = bus_valid && bus_write && (bus_addr == A_ACC);
  assign wr_ctrl = bus_valid && bus_write && (bus_addr == A_CTRL);
  assign rd_req  = bus_valid && !bus_write;

  phy_acc_cmd u_cmd (
    .clk, .rst_n, .wr_acc, .wdata(bus_wdata),
    .eng_done, .eng_rdata, .eng_rderr,
    .eng_start, .is_wr, .fields, .busy, .done, .rd_err_evt
  );

  phy_acc_stat u_stat (
    .clk, .rst_n, .wr_ctrl, .wdata(bus_wdata), .err_evt(rd_err_evt),
    .err, .err_en, .blk_mode, .irq(err_irq)
  );

  assign eng_write = is_wr;
  assign eng_phy   = fields.phy;
  assign eng_reg   = fields.regn;
  assign eng_wdata = fields.data;

  always_comb begin
    acc_word = '0;
    acc_word[F_DATA +: DATA_W] = fields.data;
    acc_word[F_REG +: ADDR_W]  = fields.regn;
    acc_word[F_PHY +: ADDR_W]  = fields.phy;
    acc_word[F_WR]   = busy & is_wr;
    acc_word[F_RD]   = busy & ~is_wr;
    acc_word[F_DONE] = done;
    ctrl_word = '0;
    ctrl_word[C_EN]  = err_en;
    ctrl_word[C_BLK] = blk_mode;
    ctrl_word[C_ERR] = err;
    case (bus_addr)
      A_ACC:   rd_mux = acc_word;
      A_CTRL:  rd_mux = ctrl_word;
      default: rd_mux = '0;
    endcase
  end

  assign refuse = rd_req && (bus_addr == A_ACC) && blk_mode && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_retry <= refuse;
      rsp_rdata <= (rd_req && !refuse) ? rd_mux : '0;
    end
  end

  AST_RETRY_IS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (rsp_valid && rsp_rdata == '0)); // R4
  AST_NB_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !blk_mode) |=> !rsp_retry); // R4
endmodule

// File: tb/phy_acc_regctl_test.sv
module phy_acc_regctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        rsp_valid, rsp_retry;
  logic [31:0] rsp_rdata;
  logic        eng_start, eng_write;
  logic [4:0]  eng_phy, eng_reg;
  logic [15:0] eng_wdata;
  logic        eng_done = 0, eng_rderr = 0;
  logic [15:0] eng_rdata = 0;
  logic        err_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_acc_regctl uut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model
  logic [15:0] m_data; logic [4:0] m_phy, m_reg;
  bit m_done, m_busy, m_w, m_err, m_en, m_blk, m_launch;

  function automatic logic [31:0] exp_acc();
    return {3'b0, m_done, m_busy && !m_w, m_busy && m_w, m_phy, m_reg, m_data};
  endfunction
  function automatic logic [31:0] exp_ctrl();
    return {23'b0, m_err, 6'b0, m_blk, m_en};
  endfunction
  function automatic logic [31:0] mk(bit wr, bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {4'b0, rd, wr, p, r, d};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic predict(bit hw, logic [1:0] ha, logic [31:0] hd, bit ed, logic [15:0] er, bit ee);
    bit pre_busy = m_busy, set_e = 0, clr_e = 0, cmd;
    m_launch = 0;
    if (ed && pre_busy) begin
      m_busy = 0; m_done = 1;
      if (!m_w) begin m_data = er; if (ee) set_e = 1; end
    end
    if (hw && ha == 0 && !pre_busy) begin
      cmd = hd[26] | hd[27];
      if (!(cmd && hd[25:21] == 5'h1F)) begin
        m_data = hd[15:0]; m_reg = hd[20:16]; m_phy = hd[25:21];
        if (cmd) begin m_busy = 1; m_done = 0; m_w = hd[26]; m_launch = 1; end
      end
    end
    if (hw && ha == 1) begin m_en = hd[0]; m_blk = hd[1]; clr_e = hd[8]; end
    m_err = set_e | (m_err & !clr_e);
  endtask

  // one cycle of host write and/or engine completion, then port checks
  task automatic step(bit hw, logic [1:0] ha, logic [31:0] hd, bit ed, logic [15:0] er, bit ee, string tag);
    @(negedge clk);
    bus_valid = hw; bus_write = hw; bus_addr = ha; bus_wdata = hd;
    eng_done = ed; eng_rdata = er; eng_rderr = ee;
    predict(hw, ha, hd, ed, er, ee);
    @(negedge clk);
    bus_valid = 0; bus_write = 0; eng_done = 0; eng_rderr = 0;
    chk(eng_start == m_launch, tag, eng_start, m_launch);
    if (m_launch)
      chk({eng_write, eng_phy, eng_reg, eng_wdata} == {m_w, m_phy, m_reg, m_data}, tag,
          {5'b0, eng_write, eng_phy, eng_reg, eng_wdata}, {5'b0, m_w, m_phy, m_reg, m_data});
    chk(err_irq == (m_err && m_en), "R7", err_irq, m_err && m_en);
  endtask

  task automatic rd(logic [1:0] ha, string tag);
    logic [31:0] e;
    bit er;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = ha;
    er = (ha == 0) && m_blk && m_busy;
    e  = er ? 32'h0 : (ha == 0 ? exp_acc() : (ha == 1 ? exp_ctrl() : 32'h0));
    @(negedge clk);
    bus_valid = 0;
    chk(rsp_valid && rsp_retry == er, "R4", {rsp_valid, rsp_retry}, {1'b1, er});
    chk(rsp_rdata == e, tag, rsp_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_data = 0; m_phy = 0; m_reg = 0;
    {m_done, m_busy, m_w, m_err, m_en, m_blk, m_launch} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(eng_start == 0 && err_irq == 0, "R1", {eng_start, err_irq}, 0);
    rd(0, "R1"); rd(1, "R1");

    step(1, 1, 32'h1, 0, 0, 0, "R7");                          // enable irq
    step(1, 0, mk(1, 0, 5'd3, 5'd7, 16'hABCD), 0, 0, 0, "R2");   // write frame
    rd(0, "R5");
    step(1, 0, mk(0, 1, 5'd4, 5'd1, 16'h1111), 0, 0, 0, "R8");   // dropped while busy
    rd(0, "R8");
    step(0, 0, 0, 1, 16'hFFFF, 1, "R6");                        // write frame, rderr ignored
    rd(0, "R5"); rd(1, "R6");
    step(1, 0, mk(0, 1, 5'd2, 5'd4, 16'h0), 0, 0, 0, "R3");      // read frame
    step(1, 1, 32'h3, 0, 0, 0, "R4");                           // blocking on
    rd(0, "R4");
    // completion and new command in the same cycle: command dropped (R8)
    step(1, 0, mk(1, 0, 5'd9, 5'd9, 16'h9999), 1, 16'h1234, 1, "R8");
    rd(0, "R3"); rd(1, "R6");
    // clear and new error same cycle: error wins (R10)
    step(1, 0, mk(0, 1, 5'd5, 5'd5, 16'h0), 0, 0, 0, "R3");
    step(1, 1, 32'h103, 1, 16'h5A5A, 1, "R10");
    rd(1, "R10");
    step(1, 1, 32'h101, 0, 0, 0, "R10");                        // plain clear
    rd(1, "R10");
    step(1, 0, mk(1, 0, 5'h1F, 5'd2, 16'h7777), 0, 0, 0, "R9");  // reserved PHY
    rd(0, "R9");
    step(1, 0, mk(0, 0, 5'd6, 5'd3, 16'h4242), 0, 0, 0, "R11");  // fields only
    rd(0, "R11");
    step(1, 0, mk(1, 1, 5'd8, 5'd8, 16'h8888), 0, 0, 0, "R12");  // both bits
    rd(0, "R12");
    step(0, 0, 0, 1, 16'h0, 0, "R5");

    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      logic [4:0] p = ($urandom_range(0, 5) == 0) ? 5'h1F : 5'($urandom);
      case (sel)
        0, 1, 2: step(1, 0, mk(1'($urandom), 1'($urandom), p, 5'($urandom), 16'($urandom)),
                      ($urandom_range(0, 3) == 0), 16'($urandom), 1'($urandom), "R2");
        3:       step(1, 1, {23'b0, 1'($urandom), 6'b0, 2'($urandom)},
                      1'($urandom), 16'($urandom), 1'($urandom), "R10");
        4, 5:    step(0, 0, 0, 1, 16'($urandom), 1'($urandom), "R3");
        6, 7:    rd(0, "R5");
        8:       rd(1, "R6");
        default: rd(2'($urandom), "R4");
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule